// File: doc/BRIEF.md
# DMA channel control sequencer

This block holds the control and status state of a single DMA channel. Software programs it through a narrow register-write port: a source address, a destination address, a reload value for the transfer counter and a control word. The counter reload can be stored without side effects. A separate start alias stores the source address and, when the written value is nonzero, copies the reload value into the running counter and launches a sequence in the same write. While a sequence runs and the channel is enabled, the block requests transfers. Each completed transfer moves the enabled addresses forward by the programmed element size and takes one from the counter.

The bus datapath is not part of this block. A single completion strobe stands for each transfer, and two fault qualifiers carry its error response. A faulting transfer halts the channel, latches a sticky error flag and raises the interrupt. Clearing the enable bit mid-sequence pauses the channel while it stays busy. An abort command ends the sequence at once.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset all addresses, the remaining count, busy, the error flags and the interrupt are zero.
- R2: Writes to the plain address selects (0 source, 1 destination) and to the count select (2) only store the value. They never start the channel.
- R3: A write to the start alias (select 4) while idle stores the source address. It starts the channel, with the running count loaded from the reload value, only when the written data is nonzero, the reload value is nonzero and neither error flag is set. Busy is high from the next cycle.
- R4: A start-alias write while busy is ignored entirely, and the source address keeps its value.
- R5: Each accepted completion without a fault decrements the count. It advances each address whose increment bit is set (control bit 3 source, bit 4 destination) by the size code in control bits 2:1 (0 gives 1 byte, 1 gives 2 bytes, 2 and 3 give 4 bytes). An address whose increment bit is clear holds its value.
- R6: The completion that takes the count from 1 to 0 drops busy and sets the interrupt flag.
- R7: With busy high and the enable bit (control bit 0) low, the transfer request is low, completions are ignored and busy stays high. Setting the enable bit again resumes the sequence.
- R8: A control write with the abort bit (bit 5) while busy clears busy without raising the interrupt. It takes priority over a completion in the same cycle, which is then discarded.
- R9: A completion carrying a read or write fault sets the matching sticky flag, clears busy and sets the interrupt. Neither address advances past the faulting transfer.
- R10: The bus-error output is the OR of the two error flags. The read flag is cleared by writing one to control bit 30 and the write flag by writing one to control bit 29. A new fault in the same cycle as its clear wins.
- R11: While either error flag is set, a start-alias write does not start the channel.
- R12: The interrupt flag is cleared by writing one to control bit 8. A new interrupt event in the same cycle as the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 source, 1 destination, 2 count reload, 3 control, 4 start alias |
| reg_wdata | input | 32 | Register write data |
| xfer_done | input | 1 | A requested transfer completed this cycle |
| xfer_rd_fault | input | 1 | The completing transfer had a read bus error |
| xfer_wr_fault | input | 1 | The completing transfer had a write bus error |
| xfer_req | output | 1 | Channel wants to move data |
| rd_addr | output | ADDR_W | Current source address |
| wr_addr | output | ADDR_W | Current destination address |
| remaining | output | CNT_W | Transfers left in the sequence |
| busy | output | 1 | A sequence is in progress |
| enabled | output | 1 | Stored enable bit |
| rd_err | output | 1 | Sticky read error flag |
| wr_err | output | 1 | Sticky write error flag |
| bus_err | output | 1 | OR of the two error flags |
| irq | output | 1 | Channel interrupt flag |

## Verification
Three collisions matter most. The final completion can meet an abort command in the same cycle, and abort must win with no interrupt. A faulting completion can meet a write that clears that same error bit, and the flag must stay set. The last completion can meet an interrupt clear, and the interrupt must stay set. The bench drives the completion strobe and the control write in one cycle to provoke each case. A behavioural model steps alongside the design and is compared on every output each clock, and directed checks inspect the flags in the cycle after each collision.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   localparam int REG_W = 32;

   typedef enum logic [2:0] {
      SEL_SRC   = 3'd0,
      SEL_DST   = 3'd1,
      SEL_COUNT = 3'd2,
      SEL_CTRL  = 3'd3,
      SEL_START = 3'd4
   } reg_sel_e;

   localparam int CB_EN       = 0;
   localparam int CB_SIZE_LO  = 1;
   localparam int CB_SRC_INC  = 3;
   localparam int CB_DST_INC  = 4;
   localparam int CB_ABORT    = 5;
   localparam int CB_IRQ_CLR  = 8;
   localparam int CB_WERR_CLR = 29;
   localparam int CB_RERR_CLR = 30;

   typedef struct packed {
      logic       dst_inc;
      logic       src_inc;
      logic [1:0] size;
      logic       en;
   } ctrl_t;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step,
   input  logic              inc_en,
   input  logic [1:0]        size,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] stride;
   assign stride = ADDR_W'(size_bytes(size));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         addr <= '0;
      else if (load)
         addr <= load_val;
      else if (step && inc_en)
         addr <= addr + stride;
   end

   a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !(step && inc_en)) |=> addr == $past(addr));

   a_r5_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && step && inc_en) |=> addr != $past(addr));

endmodule

// File: rtl/dma_seq_core.sv
module dma_seq_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] reload,
   input  logic             accept,
   input  logic             fault,
   input  logic             abort,
   output logic             busy,
   output logic [CNT_W-1:0] count,
   output logic             last_done,
   output logic             fault_halt
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic done_ok;

   assign done_ok    = accept && !fault && !abort;
   assign fault_halt = accept && fault && !abort;
   assign last_done  = done_ok && (count == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         count <= '0;
      end else if (abort || fault_halt) begin
         busy <= 1'b0;
      end else if (done_ok) begin
         count <= count - ONE;
         if (count == ONE)
            busy <= 1'b0;
      end else if (start) begin
         busy  <= 1'b1;
         count <= reload;
      end
   end

   a_r3_busy_has_work: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> count != '0);

   a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy && count == $past(reload));

   a_r5_count_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (done_ok && count > ONE) |=> busy && count == $past(count) - ONE);

   a_r6_last_idles: assert property (@(posedge clk) disable iff (!rst_n)
      last_done |=> !busy && count == '0);

   a_r8_abort_idles: assert property (@(posedge clk) disable iff (!rst_n)
      abort |=> !busy && count == $past(count));

endmodule

// File: rtl/dma_err_status.sv
module dma_err_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set_rd,
   input  logic set_wr,
   input  logic set_irq,
   input  logic clr_rd,
   input  logic clr_wr,
   input  logic clr_irq,
   output logic rd_err,
   output logic wr_err,
   output logic irq
);

   localparam int NFLAG = 3;

   logic [NFLAG-1:0] set_v, clr_v, flag_q;

   assign set_v = {set_irq, set_wr, set_rd};
   assign clr_v = {clr_irq, clr_wr, clr_rd};

   for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q[i] <= 1'b0;
         else if (set_v[i])
            flag_q[i] <= 1'b1;
         else if (clr_v[i])
            flag_q[i] <= 1'b0;
      end

      a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_v[i] |=> flag_q[i]);

      a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_q[i] && !clr_v[i]) |=> flag_q[i]);
   end

   assign rd_err = flag_q[0];
   assign wr_err = flag_q[1];
   assign irq    = flag_q[2];

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_sel,
   input  logic [31:0]       reg_wdata,
   input  logic              xfer_done,
   input  logic              xfer_rd_fault,
   input  logic              xfer_wr_fault,
   output logic              xfer_req,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [CNT_W-1:0]  remaining,
   output logic              busy,
   output logic              enabled,
   output logic              rd_err,
   output logic              wr_err,
   output logic              bus_err,
   output logic              irq
);

   localparam int NADDR = 2;

   if (ADDR_W < 8 || ADDR_W > REG_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 8 and the register width");
   end
   if (CNT_W < 2 || CNT_W > REG_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and the register width");
   end

   reg_sel_e         sel;
   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] reload_q;
   logic             wr_src, wr_dst, wr_cnt, wr_ctrl, wr_start;
   logic             start_take, start_go, abort_req;
   logic             accept, fault, step;
   logic             last_done, fault_halt;

   assign sel      = reg_sel_e'(reg_sel);
   assign wr_src   = reg_wr && (sel == SEL_SRC);
   assign wr_dst   = reg_wr && (sel == SEL_DST);
   assign wr_cnt   = reg_wr && (sel == SEL_COUNT);
   assign wr_ctrl  = reg_wr && (sel == SEL_CTRL);
   assign wr_start = reg_wr && (sel == SEL_START);

   assign abort_req  = wr_ctrl && reg_wdata[CB_ABORT] && busy;
   assign start_take = wr_start && !busy;
   assign start_go   = start_take && (reg_wdata != '0) && (reload_q != '0)
                       && !rd_err && !wr_err;

   assign xfer_req = busy && ctrl_q.en;
   assign accept   = xfer_done && xfer_req;
   assign fault    = xfer_rd_fault || xfer_wr_fault;
   assign step     = accept && !fault && !abort_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q.en      <= reg_wdata[CB_EN];
            ctrl_q.size    <= reg_wdata[CB_SIZE_LO +: 2];
            ctrl_q.src_inc <= reg_wdata[CB_SRC_INC];
            ctrl_q.dst_inc <= reg_wdata[CB_DST_INC];
         end
         if (wr_cnt)
            reload_q <= reg_wdata[CNT_W-1:0];
      end
   end

   logic [NADDR-1:0]  ld_v, inc_v;
   logic [ADDR_W-1:0] addr_v [NADDR];

   assign ld_v  = {wr_dst, wr_src || start_take};
   assign inc_v = {ctrl_q.dst_inc, ctrl_q.src_inc};

   for (genvar i = 0; i < NADDR; i++) begin : g_addr
      dma_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ld_v[i]),
         .load_val (reg_wdata[ADDR_W-1:0]),
         .step     (step),
         .inc_en   (inc_v[i]),
         .size     (ctrl_q.size),
         .addr     (addr_v[i])
      );
   end

   assign rd_addr = addr_v[0];
   assign wr_addr = addr_v[1];

   dma_seq_core #(.CNT_W(CNT_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_go),
      .reload     (reload_q),
      .accept     (accept),
      .fault      (fault),
      .abort      (abort_req),
      .busy       (busy),
      .count      (remaining),
      .last_done  (last_done),
      .fault_halt (fault_halt)
   );

   dma_err_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_rd  (fault_halt && xfer_rd_fault),
      .set_wr  (fault_halt && xfer_wr_fault),
      .set_irq (last_done || fault_halt),
      .clr_rd  (wr_ctrl && reg_wdata[CB_RERR_CLR]),
      .clr_wr  (wr_ctrl && reg_wdata[CB_WERR_CLR]),
      .clr_irq (wr_ctrl && reg_wdata[CB_IRQ_CLR]),
      .rd_err  (rd_err),
      .wr_err  (wr_err),
      .irq     (irq)
   );

   assign enabled = ctrl_q.en;
   assign bus_err = rd_err || wr_err;

   a_r4_start_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_start && busy && !step) |=> rd_addr == $past(rd_addr));

   a_r7_pause_keeps_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !ctrl_q.en && !abort_req) |=> busy && remaining == $past(remaining));

   a_r9_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && fault && !abort_req) |=> !busy && irq && bus_err);

   a_r9_fault_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && fault && !abort_req && !reg_wr) |=>
         rd_addr == $past(rd_addr) && wr_addr == $past(wr_addr));

   a_r11_no_start_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_err || wr_err) && !busy) |=> !busy);

   a_r8_abort_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_req && !irq) |=> !irq);

endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;

   localparam int AW = 32;
   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_sel = 3'd0;
   logic [31:0]   reg_wdata = 32'd0;
   logic          xfer_done = 1'b0;
   logic          xfer_rd_fault = 1'b0;
   logic          xfer_wr_fault = 1'b0;
   logic          xfer_req, busy, enabled, rd_err, wr_err, bus_err, irq;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [CW-1:0] remaining;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   dma_chan_seq #(.ADDR_W(AW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .xfer_done(xfer_done),
      .xfer_rd_fault(xfer_rd_fault), .xfer_wr_fault(xfer_wr_fault),
      .xfer_req(xfer_req), .rd_addr(rd_addr), .wr_addr(wr_addr),
      .remaining(remaining), .busy(busy), .enabled(enabled),
      .rd_err(rd_err), .wr_err(wr_err), .bus_err(bus_err), .irq(irq)
   );

   // behavioural reference
   logic [31:0] m_rd, m_wr;
   logic [15:0] m_reload, m_cnt;
   logic [1:0]  m_size;
   bit m_en, m_rinc, m_winc, m_busy, m_rerr, m_werr, m_irq;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_rd = 0; m_wr = 0; m_reload = 0; m_cnt = 0; m_size = 0;
         m_en = 0; m_rinc = 0; m_winc = 0; m_busy = 0;
         m_rerr = 0; m_werr = 0; m_irq = 0;
      end else begin
         int  sz;
         bit  wc, ab, acc, flt, tt, st, lastc;
         logic [31:0] n_rd, n_wr;
         logic [15:0] n_cnt;
         bit n_busy, n_rerr, n_werr, n_irq;
         sz    = (m_size == 0) ? 1 : (m_size == 1) ? 2 : 4;
         wc    = reg_wr && reg_sel == 3;
         ab    = wc && reg_wdata[5] && m_busy;
         acc   = xfer_done && m_busy && m_en && !ab;
         flt   = xfer_rd_fault || xfer_wr_fault;
         tt    = reg_wr && reg_sel == 4 && !m_busy;
         st    = tt && reg_wdata != 0 && !m_rerr && !m_werr && m_reload != 0;
         lastc = acc && !flt && m_cnt == 1;
         n_rd = m_rd; n_wr = m_wr; n_cnt = m_cnt; n_busy = m_busy;
         if ((reg_wr && reg_sel == 0) || tt) n_rd = reg_wdata;
         else if (acc && !flt && m_rinc) n_rd = m_rd + sz;
         if (reg_wr && reg_sel == 1) n_wr = reg_wdata;
         else if (acc && !flt && m_winc) n_wr = m_wr + sz;
         if (ab) n_busy = 0;
         else if (acc && flt) n_busy = 0;
         else if (acc) begin
            n_cnt = m_cnt - 1;
            if (m_cnt == 1) n_busy = 0;
         end else if (st) begin
            n_busy = 1; n_cnt = m_reload;
         end
         n_rerr = (acc && xfer_rd_fault) ? 1'b1 : (wc && reg_wdata[30]) ? 1'b0 : m_rerr;
         n_werr = (acc && xfer_wr_fault) ? 1'b1 : (wc && reg_wdata[29]) ? 1'b0 : m_werr;
         n_irq  = (lastc || (acc && flt)) ? 1'b1 : (wc && reg_wdata[8]) ? 1'b0 : m_irq;
         if (wc) begin
            m_en = reg_wdata[0]; m_size = reg_wdata[2:1];
            m_rinc = reg_wdata[3]; m_winc = reg_wdata[4];
         end
         if (reg_wr && reg_sel == 2) m_reload = reg_wdata[15:0];
         m_rd = n_rd; m_wr = n_wr; m_cnt = n_cnt; m_busy = n_busy;
         m_rerr = n_rerr; m_werr = n_werr; m_irq = n_irq;
      end
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, midway between the edges
   always @(posedge clk) begin
      #5;
      if (rst_n && !finished) begin
         chk(rd_addr == m_rd,   "R5 rd_addr",   rd_addr,   m_rd);
         chk(wr_addr == m_wr,   "R5 wr_addr",   wr_addr,   m_wr);
         chk(remaining == m_cnt, "R5 remaining", remaining, m_cnt);
         chk(busy == m_busy,    "R6 busy",      busy,      m_busy);
         chk(enabled == m_en,   "R7 enabled",   enabled,   m_en);
         chk(xfer_req == (m_busy && m_en), "R7 xfer_req", xfer_req, m_busy && m_en);
         chk(rd_err == m_rerr,  "R9 rd_err",    rd_err,    m_rerr);
         chk(wr_err == m_werr,  "R9 wr_err",    wr_err,    m_werr);
         chk(bus_err == (m_rerr || m_werr), "R10 bus_err", bus_err, m_rerr || m_werr);
         chk(irq == m_irq,      "R12 irq",      irq,       m_irq);
      end
   end

   task automatic step(input bit dn, input bit rf, input bit wf,
                       input bit w, input logic [2:0] s, input logic [31:0] d);
      @(negedge clk);
      xfer_done = dn; xfer_rd_fault = rf; xfer_wr_fault = wf;
      reg_wr = w; reg_sel = s; reg_wdata = d;
   endtask

   task automatic wreg(input logic [2:0] s, input logic [31:0] d);
      step(0, 0, 0, 1, s, d);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 3'd0, 32'd0);
   endtask

   task automatic done1();
      step(1, 0, 0, 0, 3'd0, 32'd0);
   endtask

   localparam logic [31:0] EN = 32'h1, RINC = 32'h8, WINC = 32'h10, ABORT = 32'h20;
   localparam logic [31:0] IRQC = 32'h100, WERRC = 32'h2000_0000, RERRC = 32'h4000_0000;

   initial begin
      #(20 * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_addr == 0 && wr_addr == 0 && remaining == 0, "R1 addr/count", rd_addr, 0);
      chk(!busy && !irq && !rd_err && !wr_err && !xfer_req, "R1 flags", busy, 0);
      rst_n = 1'b1;
      idle();

      // R2 plain writes only store
      wreg(0, 32'h100); wreg(1, 32'h200); wreg(2, 32'd3); idle();
      chk(rd_addr == 32'h100, "R2 src", rd_addr, 32'h100);
      chk(wr_addr == 32'h200, "R2 dst", wr_addr, 32'h200);
      chk(!busy && remaining == 0, "R2 no start", busy, 0);

      // R3 start alias
      wreg(3, EN | (2 << 1) | RINC);
      wreg(4, 32'd0); idle();
      chk(!busy && rd_addr == 0, "R3 zero no start", busy, 0);
      wreg(4, 32'h100); idle();
      chk(busy && remaining == 3, "R3 started", remaining, 3);

      // R5 / R6 run to completion, 4-byte source stepping
      done1(); done1(); done1(); idle();
      chk(!busy && irq, "R6 end", busy, 0);
      chk(rd_addr == 32'h10C && wr_addr == 32'h200, "R5 addr", rd_addr, 32'h10C);

      // R12 clear, 2-byte destination stepping
      wreg(3, EN | (1 << 1) | WINC | IRQC); idle();
      chk(!irq, "R12 cleared", irq, 0);
      wreg(2, 32'd4); wreg(4, 32'h300); done1();
      // R4 start alias while busy, coinciding with a completion
      step(1, 0, 0, 1, 3'd4, 32'h500); idle();
      chk(rd_addr == 32'h300 && remaining == 2, "R4 ignored", rd_addr, 32'h300);
      chk(wr_addr == 32'h204, "R5 dst step", wr_addr, 32'h204);

      // R7 pause
      wreg(3, (1 << 1) | WINC); done1(); done1(); idle();
      chk(busy && remaining == 2 && !xfer_req, "R7 paused", remaining, 2);
      wreg(3, EN | (1 << 1) | WINC); done1(); idle();
      chk(remaining == 1, "R7 resumed", remaining, 1);

      // R8 abort meets the final completion
      step(1, 0, 0, 1, 3'd3, EN | (1 << 1) | WINC | ABORT); idle();
      chk(!busy && !irq && remaining == 1, "R8 abort wins", irq, 0);

      // R9 read fault
      wreg(2, 32'd5); wreg(4, 32'h700); done1();
      step(1, 1, 0, 0, 3'd0, 32'd0); idle();
      chk(!busy && rd_err && bus_err && irq, "R9 halt", busy, 0);
      chk(wr_addr == 32'h208, "R9 addr kept", wr_addr, 32'h208);
      // R11 refused start
      wreg(4, 32'h800); idle();
      chk(!busy, "R11 refused", busy, 0);
      wreg(3, EN | (1 << 1) | WINC | RERRC | IRQC); idle();
      chk(!rd_err && !bus_err, "R10 rd clear", rd_err, 0);

      // R10 fault beats its own clear
      wreg(4, 32'h900); idle();
      step(1, 0, 1, 1, 3'd3, EN | (1 << 1) | WINC | WERRC); idle();
      chk(wr_err && !busy, "R10 set wins", wr_err, 1);
      wreg(3, EN | WERRC | IRQC); idle();
      chk(!wr_err && !irq, "R10 wr clear", wr_err, 0);

      // R3 zero reload does not start
      wreg(2, 32'd0); wreg(4, 32'hA00); idle();
      chk(!busy, "R3 zero reload", busy, 0);

      // R12 last completion beats interrupt clear, 1-byte steps
      wreg(3, EN | RINC | WINC); wreg(2, 32'd2); wreg(4, 32'hA00); done1();
      step(1, 0, 0, 1, 3'd3, EN | RINC | WINC | IRQC); idle();
      chk(irq && !busy, "R12 set wins", irq, 1);
      chk(rd_addr == 32'hA02, "R5 byte step", rd_addr, 32'hA02);

      idle(); idle();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule